// File: doc/BRIEF.md
# Scrambled RAM Access Controller

This block stands between a bus port that allows one outstanding request and a word-addressed RAM held inside it. Every address is remapped and every data word is masked with values derived from a scrambling key and nonce. Software can ask for a fresh key at any time. The block then raises a request towards a one-time-programmable key source and holds it until a valid pulse delivers the key and nonce. While that request is open, memory traffic is refused.

Each stored word carries one even-parity bit per byte, taken over the scrambled data. A read that finds a parity mismatch is reported as a fault, and so is an asserted escalation input. Either event puts the block into a locked state that lasts until reset. In that state the key and nonce are cleared, every access completes with an error response, and a parity fault also raises the alert and records the logical address that failed. Blocked, out-of-range and faulty accesses all complete in the normal response cycle with the error flag set and zero data, so the requester never waits.

Top module: `scr_ram_ctrl`

## Requirements
- R1: After reset, `rsp_valid_o`, `key_req_o`, `locked_o`, `parity_err_o` and `alert_o` are 0, `req_ready_o` is 1 and `fault_addr_o` is 0. The key and nonce are both zero, and accesses are allowed at once.
- R2: A request is accepted when `req_valid_i` and `req_ready_o` are both 1. Its response appears as a one-cycle `rsp_valid_o` pulse on the next cycle, and `req_ready_o` is 0 while that response is shown. Only one transaction is outstanding, including back-to-back requests to the same address.
- R3: A read of an address written under the current key and nonce returns the written data, with `rsp_err_o` at 0. A successful write responds with `rsp_err_o` 0 and zero data.
- R4: For every key, logical addresses 0 to DEPTH-1 land on distinct physical words, so writing every address and then reading each one back returns its own value.
- R5: A `key_renew_i` pulse while no renewal is open sets `key_req_o` on the next cycle. `key_req_o` stays high until `key_valid_i` is sampled high, then falls on the following cycle and the delivered key and nonce take effect. An access accepted in the same cycle as the renew pulse is still served.
- R6: Any access accepted while `key_req_o` is high has no effect on memory. It completes with `rsp_err_o` 1 and zero data, and this includes the cycle in which `key_valid_i` arrives.
- R7: A newly delivered key replaces the previous scrambling state. Data written after the delivery reads back correctly under the new key.
- R8: A high `escalate_i` sets `locked_o` on the next cycle, and `locked_o` stays set until reset. The key and nonce are cleared, `key_req_o` drops, and `key_renew_i` is ignored while locked.
- R9: A read whose stored parity does not match completes with `rsp_err_o` 1 and zero data. On the same cycle, `parity_err_o`, `alert_o` and `locked_o` rise, and `fault_addr_o` holds the logical address of that read and keeps it.
- R10: While `locked_o` is 1, every accepted access completes with `rsp_err_o` 1 and zero data. After reset, normal reads and writes work again.
- R11: An access to an address at or above DEPTH completes with `rsp_err_o` 1 and zero data and writes nothing.
- R12: An access accepted in the same cycle that `escalate_i` is high is blocked: `rsp_err_o` is 1 and memory is untouched.
- R13: A write with `par_inject_i` at 1 stores the word with the parity bit of byte 0 inverted. A later read of that word is a parity fault (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Logical word address |
| req_wdata_i | input | DATA_W | Write data |
| par_inject_i | input | 1 | Corrupt the byte-0 parity bit of this write (fault test) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Response carries an error |
| rsp_rdata_o | output | DATA_W | Read data, zero on error or write |
| key_renew_i | input | 1 | Software pulse asking for a new key |
| key_req_o | output | 1 | Key request to the key source (renewal pending) |
| key_valid_i | input | 1 | Key source delivers key and nonce |
| key_i | input | DATA_W | Delivered key |
| nonce_i | input | DATA_W | Delivered nonce |
| escalate_i | input | 1 | Lifecycle escalation |
| locked_o | output | 1 | Terminal locked state |
| parity_err_o | output | 1 | Sticky parity-fault status |
| fault_addr_o | output | ADDR_W | Logical address of the faulty read |
| alert_o | output | 1 | Alert raised on a parity fault |

## Verification
A key renewal and a bus access can fall in the same cycle. So can an escalation and an accepted access. The bench provokes the first by raising `key_renew_i` together with an accepted write. That write must be served, because the pending state only starts on the following cycle. It is then confirmed by delivering the same key again and reading the word back. The bench provokes the second by raising `escalate_i` on the cycle a write is accepted, and expects an error response and an immediately locked block. A behavioural model that tracks stored words together with the key and nonce they were written under predicts every output on every clock.

// File: rtl/scr_ram_pkg.sv
// Shared constants and types for the scrambled RAM controller.
// Assumes DATA_W of the users is at most 64 bits.
package scr_ram_pkg;

    // Odd mixing constant used to spread the physical address into the keystream.
    localparam logic [63:0] SCR_MIX = 64'h9E37_79B9_7F4A_7C15;

    // Outcome of an accepted access.
    typedef enum logic [1:0] {
        OUT_DONE    = 2'd0,
        OUT_BLOCKED = 2'd1,
        OUT_FAULT   = 2'd2
    } outcome_e;

endpackage

// File: rtl/scr_ram_scrambler.sv
// Purely combinational scrambling functions.
// Physical address = rotate-left(logical XOR low key bits, ROT), which is a
// bijection for every key. Keystream = nonce XOR key XOR (phys * mix const).
// Assumes ADDR_W <= DATA_W <= 64.
module scr_ram_scrambler
    import scr_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ROT    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic [DATA_W-1:0] nonce_i,
    output logic [ADDR_W-1:0] phys_o,
    output logic [DATA_W-1:0] ks_o
);
    localparam int unsigned R = ROT % ADDR_W;
    localparam logic [DATA_W-1:0] MIX = SCR_MIX[DATA_W-1:0];

    logic [ADDR_W-1:0] mixed;

    // Key-dependent XOR of the logical address.
    assign mixed = addr_i ^ key_i[ADDR_W-1:0];

    generate
        if (R == 0) begin : g_norot
            assign phys_o = mixed;
        end else begin : g_rot
            assign phys_o = {mixed[ADDR_W-1-R:0], mixed[ADDR_W-1:ADDR_W-R]};
        end
    endgenerate

    // Keystream word bound to key, nonce and physical location.
    assign ks_o = nonce_i ^ key_i ^ (DATA_W'(phys_o) * MIX);

endmodule

// File: rtl/scr_ram_array.sv
// Behavioural RAM of 2**ADDR_W words, each with one even-parity bit per byte.
// Write is synchronous, read is combinational on the same address.
// Assumes DATA_W is a multiple of 8. Contents are not reset.
module scr_ram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic              flip_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              par_ok_o
);
    localparam int unsigned NB    = DATA_W / 8;
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [DATA_W+NB-1:0] mem [WORDS];
    logic [DATA_W+NB-1:0] word;
    logic [NB-1:0]        wpar;
    logic [NB-1:0]        bad;
    logic [NB-1:0]        flip_mask;

    assign flip_mask = {{(NB-1){1'b0}}, flip_i};

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign wpar[b] = ^wdata_i[b*8 +: 8];
            assign bad[b]  = ^{word[b*8 +: 8], word[DATA_W+b]};
        end
    endgenerate

    // Store data and parity (byte-0 parity optionally inverted).
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[addr_i] <= {wpar ^ flip_mask, wdata_i};
        end
    end

    assign word     = mem[addr_i];
    assign rdata_o  = word[DATA_W-1:0];
    assign par_ok_o = ~|bad;

endmodule

// File: rtl/scr_ram_key_ctl.sv
// Holds the current key and nonce and the renewal-pending flag.
// A renew pulse opens a request; a valid pulse while open loads the key and
// closes it. Lock clears key, nonce and pending, and blocks any new request.
module scr_ram_key_ctl #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              renew_i,
    input  logic              key_valid_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic [DATA_W-1:0] nonce_i,
    input  logic              lock_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] key_o,
    output logic [DATA_W-1:0] nonce_o
);
    logic              pend_q;
    logic [DATA_W-1:0] key_q;
    logic [DATA_W-1:0] nonce_q;

    // Pending flag and key state update.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q  <= 1'b0;
            key_q   <= '0;
            nonce_q <= '0;
        end else if (lock_i) begin
            pend_q  <= 1'b0;
            key_q   <= '0;
            nonce_q <= '0;
        end else if (pend_q && key_valid_i) begin
            pend_q  <= 1'b0;
            key_q   <= key_i;
            nonce_q <= nonce_i;
        end else if (renew_i && !pend_q) begin
            pend_q  <= 1'b1;
        end
    end

    assign pend_o  = pend_q;
    assign key_o   = key_q;
    assign nonce_o = nonce_q;

endmodule

// File: rtl/scr_ram_lock.sv
// Sticky fault latches: escalation and parity fault, plus the faulty address.
// The first parity fault's address is kept until reset.
module scr_ram_lock #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              escalate_i,
    input  logic              par_fail_i,
    input  logic [ADDR_W-1:0] fail_addr_i,
    output logic              esc_o,
    output logic              par_o,
    output logic [ADDR_W-1:0] fault_addr_o
);
    logic              esc_q;
    logic              par_q;
    logic [ADDR_W-1:0] addr_q;

    // Escalation latch.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) esc_q <= 1'b0;
        else if (escalate_i) esc_q <= 1'b1;
    end

    // Parity fault latch with address capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            par_q  <= 1'b0;
            addr_q <= '0;
        end else if (par_fail_i && !par_q) begin
            par_q  <= 1'b1;
            addr_q <= fail_addr_i;
        end
    end

    assign esc_o        = esc_q;
    assign par_o        = par_q;
    assign fault_addr_o = addr_q;

endmodule

// File: rtl/scr_ram_ctrl.sv
// Top of the scrambled RAM controller. Accepts one request at a time,
// scrambles address and data with the current key, gates traffic on
// key-pending, lock and range, and answers one cycle after acceptance.
// Assumes DEPTH <= 2**ADDR_W and DATA_W a multiple of 8, at most 64.
module scr_ram_ctrl
    import scr_ram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 48,
    parameter int unsigned ROT    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              par_inject_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    input  logic              key_renew_i,
    output logic              key_req_o,
    input  logic              key_valid_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic [DATA_W-1:0] nonce_i,
    input  logic              escalate_i,
    output logic              locked_o,
    output logic              parity_err_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic              alert_o
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic              acc, oob, blocked, pend, esc_q, par_q, par_ok, par_fail, mem_we;
    logic [DATA_W-1:0] cur_key, cur_nonce, ks, raw;
    logic [ADDR_W-1:0] phys;
    outcome_e          outcome;

    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    assign req_ready_o = ~rsp_valid_q;
    assign acc         = req_valid_i & req_ready_o;
    assign oob         = {1'b0, req_addr_i} >= LIMIT;
    assign locked_o    = esc_q | par_q;
    assign blocked     = locked_o | escalate_i | pend | oob;

    scr_ram_key_ctl #(.DATA_W(DATA_W)) u_key (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .renew_i     (key_renew_i),
        .key_valid_i (key_valid_i),
        .key_i       (key_i),
        .nonce_i     (nonce_i),
        .lock_i      (locked_o | escalate_i),
        .pend_o      (pend),
        .key_o       (cur_key),
        .nonce_o     (cur_nonce)
    );

    scr_ram_scrambler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROT(ROT)) u_scr (
        .addr_i  (req_addr_i),
        .key_i   (cur_key),
        .nonce_i (cur_nonce),
        .phys_o  (phys),
        .ks_o    (ks)
    );

    scr_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk_i    (clk_i),
        .we_i     (mem_we),
        .flip_i   (par_inject_i),
        .addr_i   (phys),
        .wdata_i  (req_wdata_i ^ ks),
        .rdata_o  (raw),
        .par_ok_o (par_ok)
    );

    // Classify the access presented this cycle.
    always_comb begin
        if (blocked)                        outcome = OUT_BLOCKED;
        else if (!req_write_i && !par_ok)   outcome = OUT_FAULT;
        else                                outcome = OUT_DONE;
    end

    assign mem_we   = acc & (outcome == OUT_DONE) & req_write_i;
    assign par_fail = acc & (outcome == OUT_FAULT);

    scr_ram_lock #(.ADDR_W(ADDR_W)) u_lock (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .escalate_i   (escalate_i),
        .par_fail_i   (par_fail),
        .fail_addr_i  (req_addr_i),
        .esc_o        (esc_q),
        .par_o        (par_q),
        .fault_addr_o (fault_addr_o)
    );

    // Register the single response one cycle after acceptance.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= acc;
            rsp_err_q   <= acc & (outcome != OUT_DONE);
            rsp_rdata_q <= (acc && outcome == OUT_DONE && !req_write_i) ? (raw ^ ks) : '0;
        end
    end

    assign rsp_valid_o  = rsp_valid_q;
    assign rsp_err_o    = rsp_err_q;
    assign rsp_rdata_o  = rsp_rdata_q;
    assign key_req_o    = pend;
    assign parity_err_o = par_q;
    assign alert_o      = par_q;

endmodule

// File: rtl/scr_ram_ctrl_chk.sv
// Property checker for scr_ram_ctrl, attached with bind below.
module scr_ram_ctrl_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 48
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              escalate_i,
    input logic              key_valid_i,
    input logic              rsp_valid_o,
    input logic              rsp_err_o,
    input logic [DATA_W-1:0] rsp_rdata_o,
    input logic              key_req_o,
    input logic              locked_o,
    input logic              parity_err_o,
    input logic              alert_o,
    input logic [ADDR_W-1:0] fault_addr_o,
    input logic [DATA_W-1:0] cur_key,
    input logic [DATA_W-1:0] cur_nonce
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> !req_ready_o);
    p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> rsp_valid_o);
    p_req_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_req_o && !key_valid_i && !locked_o && !escalate_i) |=> key_req_o);
    p_req_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_req_o && key_valid_i) |=> !key_req_o);
    p_pend_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && key_req_o) |=> rsp_err_o);
    p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0));
    p_esc_locks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        escalate_i |=> locked_o);
    p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> locked_o);
    p_lock_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && $past(locked_o)) |-> (cur_key == '0 && cur_nonce == '0 && !key_req_o));
    p_alert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        parity_err_o |-> (alert_o && locked_o));
    p_fault_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (parity_err_o && $past(parity_err_o)) |-> $stable(fault_addr_o));
    p_locked_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && locked_o) |=> rsp_err_o);
    p_oob_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && ({1'b0, req_addr_i} >= LIMIT)) |=> rsp_err_o);
    p_esc_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && escalate_i) |=> rsp_err_o);

endmodule

bind scr_ram_ctrl scr_ram_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .escalate_i   (escalate_i),
    .key_valid_i  (key_valid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .key_req_o    (key_req_o),
    .locked_o     (locked_o),
    .parity_err_o (parity_err_o),
    .alert_o      (alert_o),
    .fault_addr_o (fault_addr_o),
    .cur_key      (cur_key),
    .cur_nonce    (cur_nonce)
);

// File: tb/scr_ram_ctrl_bench.sv
`timescale 1ns/1ps
module scr_ram_ctrl_bench;
    localparam int AW = 6, DW = 32, DEPTH = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 0, req_write = 0, par_inject = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, key_in = '0, nonce_in = '0;
    logic          key_renew = 0, key_valid = 0, escalate = 0;
    logic          req_ready_o, rsp_valid_o, rsp_err_o, key_req_o, locked_o, parity_err_o, alert_o;
    logic [DW-1:0] rsp_rdata_o;
    logic [AW-1:0] fault_addr_o;

    scr_ram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_scr_ram_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .par_inject_i(par_inject),
        .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
        .key_renew_i(key_renew), .key_req_o(key_req_o), .key_valid_i(key_valid),
        .key_i(key_in), .nonce_i(nonce_in), .escalate_i(escalate),
        .locked_o(locked_o), .parity_err_o(parity_err_o), .fault_addr_o(fault_addr_o),
        .alert_o(alert_o)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    bit    model_on = 0, done = 0;

    // Behavioural reference model state.
    logic [DW-1:0]   m_data [64];
    bit              m_wr   [64];
    bit              m_bad  [64];
    logic [2*DW-1:0] m_tag  [64];
    bit              m_busy, m_pend, m_esc, m_par;
    logic [DW-1:0]   m_key, m_nonce, e_rd;
    int              m_fault;
    bit              e_valid, e_err, e_known, acc, lk, blk, par_set;
    int              a;

    // Predict outputs at each rising edge from the inputs driven before it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_esc = 0; m_par = 0; m_fault = 0;
            m_key = '0; m_nonce = '0;
            e_valid = 0; e_err = 0; e_rd = '0; e_known = 1;
        end else begin
            acc = req_valid && !m_busy;
            lk  = m_esc || m_par;
            a   = int'(req_addr);
            blk = lk || escalate || m_pend || (a >= DEPTH);
            e_valid = acc; e_err = 0; e_rd = '0; e_known = 1; par_set = 0;
            if (acc) begin
                if (blk) e_err = 1;
                else if (req_write) begin
                    m_data[a] = req_wdata; m_wr[a] = 1; m_bad[a] = par_inject;
                    m_tag[a] = {m_key, m_nonce};
                end else if (m_bad[a]) begin
                    e_err = 1; par_set = 1;
                end else if (m_wr[a] && m_tag[a] == {m_key, m_nonce}) e_rd = m_data[a];
                else e_known = 0;
            end
            if (lk || escalate) begin
                m_pend = 0; m_key = '0; m_nonce = '0;
            end else if (m_pend && key_valid) begin
                m_pend = 0; m_key = key_in; m_nonce = nonce_in;
            end else if (key_renew && !m_pend) m_pend = 1;
            if (escalate) m_esc = 1;
            if (par_set && !m_par) begin m_par = 1; m_fault = a; end
            m_busy = acc;
        end
        model_on = 1;
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            n_chk++;
            if ({rsp_valid_o, req_ready_o, key_req_o, locked_o, alert_o, parity_err_o} !==
                {e_valid, !e_valid, m_pend, m_esc | m_par, m_par, m_par}) begin
                n_fail++;
                $display("FAIL %s status {vld,rdy,kreq,lock,alert,perr} act=%b exp=%b", cur_tag,
                    {rsp_valid_o, req_ready_o, key_req_o, locked_o, alert_o, parity_err_o},
                    {e_valid, !e_valid, m_pend, m_esc | m_par, m_par, m_par});
            end
            if (e_valid) begin
                n_chk++;
                if (rsp_err_o !== e_err || (e_known && rsp_rdata_o !== e_rd)) begin
                    n_fail++;
                    $display("FAIL %s response err/data act=%0b/%h exp=%0b/%h",
                             cur_tag, rsp_err_o, rsp_rdata_o, e_err, e_rd);
                end
            end
            if (m_par) begin
                n_chk++;
                if (int'(fault_addr_o) != m_fault) begin
                    n_fail++;
                    $display("FAIL R9 fault_addr act=%0d exp=%0d", fault_addr_o, m_fault);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // One access: waits for ready, presents one cycle, samples the response.
    task automatic access(input bit wr, input int addr, input logic [DW-1:0] d,
                          input bit inj, output bit err, output logic [DW-1:0] rd);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(addr); req_wdata = d; par_inject = inj;
        @(negedge clk);
        req_valid = 0; par_inject = 0;
        chk(rsp_valid_o && !req_ready_o, "R2", "response next cycle, ready low", rsp_valid_o, 1);
        err = rsp_err_o; rd = rsp_rdata_o;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic deliver_key(input logic [DW-1:0] k, input logic [DW-1:0] n);
        key_valid = 1; key_in = k; nonce_in = n;
        @(negedge clk);
        key_valid = 0;
        chk(key_req_o == 0, "R5", "key_req after delivery", key_req_o, 0);
    endtask

    task automatic load_key(input logic [DW-1:0] k, input logic [DW-1:0] n);
        @(negedge clk); key_renew = 1;
        @(negedge clk); key_renew = 0;
        chk(key_req_o == 1, "R5", "key_req after renew", key_req_o, 1);
        repeat (3) @(negedge clk);
        chk(key_req_o == 1, "R5", "key_req held", key_req_o, 1);
        deliver_key(k, n);
    endtask

    bit            err;
    logic [DW-1:0] rd;
    int            resp_cnt;

    initial begin
        #(8ns * 200000);
        if (!done) begin
            done = 1; n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        cur_tag = "R1";
        chk(!rsp_valid_o && req_ready_o && !key_req_o && !locked_o && !alert_o && !parity_err_o
            && fault_addr_o == 0, "R1", "reset outputs", {rsp_valid_o, key_req_o, locked_o}, 0);

        cur_tag = "R5"; load_key(32'h1234_5678, 32'hCAFE_F00D);

        cur_tag = "R3";
        for (int i = 0; i < 4; i++) access(1, 3 + i, 32'h1111_0000 + i, 0, err, rd);
        for (int i = 0; i < 4; i++) begin
            access(0, 3 + i, '0, 0, err, rd);
            chk(!err && rd == 32'h1111_0000 + i, "R3", "read back", rd, 32'h1111_0000 + i);
        end

        cur_tag = "R4";
        for (int i = 0; i < DEPTH; i++) access(1, i, 32'hA5A5_0000 | i, 0, err, rd);
        for (int i = 0; i < DEPTH; i++) begin
            access(0, i, '0, 0, err, rd);
            chk(!err && rd == (32'hA5A5_0000 | i), "R4", "distinct words", rd, 32'hA5A5_0000 | i);
        end

        cur_tag = "R2";
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 6'd10; req_wdata = 32'hBEEF_0010;
        resp_cnt = 0;
        @(negedge clk); resp_cnt += int'(rsp_valid_o); req_write = 0;
        @(negedge clk); resp_cnt += int'(rsp_valid_o);
        @(negedge clk); resp_cnt += int'(rsp_valid_o); rd = rsp_rdata_o; req_valid = 0;
        chk(resp_cnt == 2, "R2", "responses over 3 held cycles", resp_cnt, 2);
        chk(rd == 32'hBEEF_0010, "R2", "back-to-back same address read", rd, 32'hBEEF_0010);

        cur_tag = "R6";
        access(1, 12, 32'h0000_AAAA, 0, err, rd);
        @(negedge clk); key_renew = 1; @(negedge clk); key_renew = 0;
        access(1, 12, 32'h0000_BBBB, 0, err, rd);
        chk(err && rd == 0, "R6", "write while pending", {err, rd}, 33'h1_0000_0000);
        access(0, 12, '0, 0, err, rd);
        chk(err && rd == 0, "R6", "read while pending", {err, rd}, 33'h1_0000_0000);
        deliver_key(32'h1234_5678, 32'hCAFE_F00D);
        access(0, 12, '0, 0, err, rd);
        chk(!err && rd == 32'h0000_AAAA, "R6", "dropped write left memory", rd, 32'h0000_AAAA);

        cur_tag = "R7";
        load_key(32'h0BAD_BEE5, 32'h7777_1234);
        access(1, 30, 32'h5A5A_3030, 0, err, rd);
        access(0, 30, '0, 0, err, rd);
        chk(!err && rd == 32'h5A5A_3030, "R7", "new key read back", rd, 32'h5A5A_3030);

        cur_tag = "R5";
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 6'd5; req_wdata = 32'h0505_0505; key_renew = 1;
        @(negedge clk);
        req_valid = 0; key_renew = 0;
        chk(!rsp_err_o && key_req_o, "R5", "access with renew served", rsp_err_o, 0);
        @(negedge clk);
        deliver_key(32'h0BAD_BEE5, 32'h7777_1234);
        access(0, 5, '0, 0, err, rd);
        chk(!err && rd == 32'h0505_0505, "R5", "same-cycle write stored", rd, 32'h0505_0505);

        cur_tag = "R11";
        access(0, DEPTH, '0, 0, err, rd);
        chk(err && rd == 0, "R11", "read out of range", err, 1);
        access(1, 63, 32'hFFFF_FFFF, 0, err, rd);
        chk(err, "R11", "write out of range", err, 1);

        cur_tag = "R13";
        access(1, 20, 32'h2020_2020, 1, err, rd);
        chk(!err, "R13", "inject write accepted", err, 0);
        cur_tag = "R9";
        access(0, 20, '0, 0, err, rd);
        chk(err && rd == 0, "R9", "faulty read response", {err, rd}, 33'h1_0000_0000);
        chk(parity_err_o && alert_o && locked_o && fault_addr_o == 20, "R9", "fault status/address",
            fault_addr_o, 20);
        cur_tag = "R10";
        access(0, 3, '0, 0, err, rd);
        chk(err && rd == 0, "R10", "read while locked", err, 1);
        @(negedge clk); key_renew = 1; @(negedge clk); key_renew = 0;
        @(negedge clk);
        chk(!key_req_o, "R8", "renew ignored while locked", key_req_o, 0);

        do_reset();
        chk(!locked_o && !alert_o && !parity_err_o, "R10", "reset leaves lock", locked_o, 0);
        access(1, 9, 32'h0909_0909, 0, err, rd);
        access(0, 9, '0, 0, err, rd);
        chk(!err && rd == 32'h0909_0909, "R10", "normal after reset", rd, 32'h0909_0909);

        cur_tag = "R12";
        load_key(32'h3C3C_C3C3, 32'h0101_0101);
        access(1, 7, 32'h0707_0707, 0, err, rd);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 6'd7; req_wdata = 32'hDEAD_0007; escalate = 1;
        @(negedge clk);
        req_valid = 0; escalate = 0;
        chk(rsp_err_o && locked_o, "R12", "access with escalation blocked", rsp_err_o, 1);
        cur_tag = "R8";
        repeat (3) @(negedge clk);
        chk(locked_o && !parity_err_o && !alert_o, "R8", "escalation lock sticky", locked_o, 1);
        access(0, 7, '0, 0, err, rd);
        chk(err && rd == 0, "R8", "read after escalation", err, 1);
        @(negedge clk); key_renew = 1; @(negedge clk); key_renew = 0;
        @(negedge clk);
        chk(!key_req_o, "R8", "renew ignored after escalation", key_req_o, 0);

        do_reset();
        cur_tag = "R10";
        access(1, 40, 32'h4040_4040, 0, err, rd);
        access(0, 40, '0, 0, err, rd);
        chk(!err && rd == 32'h4040_4040, "R10", "normal after escalation reset", rd, 32'h4040_4040);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule